// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter Chain

This block is a synchronous up-counter built from identical narrow stages, each a presettable binary counter with a parallel count enable, a trickle count enable and a terminal-count flag. The stages are chained into one wider counter. Each stage's terminal-count flag drives the trickle enable of the stage above it. The parallel count enable, the active-low load and the active-low reset are shared by every stage. Typical uses are programmable dividers, where the counter is reloaded from a preset word, and long synchronous timers.

Every stage has a fixed order of modes, highest priority first: clear, load, count, hold. An elaboration parameter picks the reset style for the whole chain. With the asynchronous style the count is cleared the moment reset goes low. With the synchronous style the count is cleared at the next rising clock edge. The carry output is the terminal-count flag of the top stage. It is combinational, so it follows the trickle enable input without waiting for a clock edge.

Top module: `pcc_chain`

## Requirements
- R1: While counting, the full chain value steps by one per rising edge and wraps from all ones (0xFFF at default parameters) to zero.
- R2: When `load_n` is low and reset is inactive, `din` is copied into `count` at the next rising edge, whatever the state of either count enable.
- R3: With reset inactive and `load_n` high, the count increments only when `en_par` and `en_trk` are both high. If either one is low, `count` holds.
- R4: With `SYNC_RST` = 0, a low `rst_n` forces `count` to zero at once, without a clock edge, and overrides load and count.
- R5: With `SYNC_RST` = 1, a low `rst_n` clears `count` at the next rising edge and overrides load and count. Before that edge, `count` is unchanged.
- R6: `carry_out` is high exactly when `en_trk` is high and `count` is all ones. `en_par` has no effect on it. A change on `en_trk` reaches it with no clock edge.
- R7: Stage k+1 advances only on an edge where every lower stage holds all ones, so a carry crosses all stages in the same edge (0x0FF to 0x100, 0xFFF to 0x000).
- R8: `count` changes only on a rising clock edge, except for the asynchronous clear of R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset; its style is set by `SYNC_RST` |
| load_n | input | 1 | Active-low parallel load, shared by all stages |
| din | input | STAGES*STAGE_W | Preset word; the least significant slice goes to stage 0 |
| en_par | input | 1 | Parallel count enable, shared by all stages |
| en_trk | input | 1 | Trickle count enable into stage 0 |
| count | output | STAGES*STAGE_W | Registered count of the whole chain |
| carry_out | output | 1 | Terminal count of the top stage |

## Verification
Clear can coincide with load. Load can coincide with disabled enables. A counting edge can coincide with the ripple of carries through every stage. The bench creates the first case by driving `rst_n` low while `load_n` is low and a non-zero preset is present, and expects zero. It creates the second by loading with both enables low, and expects the preset. It creates the third by counting across 0x0FF and 0xFFF, and expects every stage to change on the same edge. The two reset styles run side by side on the same stimulus. The bench pulls reset low between clock edges and judges the difference at once: the asynchronous copy reads zero and the synchronous copy still holds its old value.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

   typedef enum logic [1:0] {
      MODE_CLEAR = 2'd0,
      MODE_LOAD  = 2'd1,
      MODE_COUNT = 2'd2,
      MODE_HOLD  = 2'd3
   } pcc_mode_t;

endpackage

// File: rtl/pcc_next.sv
module pcc_next
   import pcc_pkg::*;
#(
   parameter int W = 4
) (
   input  logic [W-1:0] q,
   input  logic [W-1:0] din,
   input  logic         clr_req,
   input  logic         load_n,
   input  logic         en_par,
   input  logic         en_trk,
   output logic [W-1:0] nxt
);

   pcc_mode_t mode;

   // fixed priority: clear, load, count, hold
   always_comb begin
      if (clr_req)                 mode = MODE_CLEAR;
      else if (!load_n)            mode = MODE_LOAD;
      else if (en_par && en_trk)   mode = MODE_COUNT;
      else                         mode = MODE_HOLD;
   end

   always_comb begin
      unique case (mode)
         MODE_CLEAR: nxt = '0;
         MODE_LOAD:  nxt = din;
         MODE_COUNT: nxt = q + W'(1);
         default:    nxt = q;
      endcase
   end

endmodule

// File: rtl/pcc_term.sv
module pcc_term #(
   parameter int W = 4
) (
   input  logic [W-1:0] q,
   input  logic         en_trk,
   output logic         tc
);

   localparam logic [W-1:0] TOP_VAL = {W{1'b1}};

   assign tc = en_trk && (q == TOP_VAL);

endmodule

// File: rtl/pcc_stage.sv
module pcc_stage #(
   parameter int W        = 4,
   parameter bit SYNC_RST = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_n,
   input  logic [W-1:0] din,
   input  logic         en_par,
   input  logic         en_trk,
   output logic [W-1:0] q,
   output logic         tc
);

   logic [W-1:0] q_r;
   logic [W-1:0] nxt;
   logic         clr_req;

   assign clr_req = SYNC_RST ? ~rst_n : 1'b0;

   pcc_next #(.W(W)) u_next (
      .q       (q_r),
      .din     (din),
      .clr_req (clr_req),
      .load_n  (load_n),
      .en_par  (en_par),
      .en_trk  (en_trk),
      .nxt     (nxt)
   );

   generate
      if (SYNC_RST) begin : g_sync_rst
         always_ff @(posedge clk) begin
            q_r <= nxt;
         end
      end else begin : g_async_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q_r <= '0;
            else        q_r <= nxt;
         end
      end
   endgenerate

   pcc_term #(.W(W)) u_term (
      .q      (q_r),
      .en_trk (en_trk),
      .tc     (tc)
   );

   assign q = q_r;

endmodule

// File: rtl/pcc_chain.sv
module pcc_chain #(
   parameter int STAGE_W  = 4,
   parameter int STAGES   = 3,
   parameter bit SYNC_RST = 1'b0
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        load_n,
   input  logic [STAGES*STAGE_W-1:0]   din,
   input  logic                        en_par,
   input  logic                        en_trk,
   output logic [STAGES*STAGE_W-1:0]   count,
   output logic                        carry_out
);

   localparam int TOTAL_W = STAGES * STAGE_W;

   generate
      if (STAGE_W < 1 || STAGE_W > 32) begin : g_bad_width
         $error("pcc_chain: STAGE_W must lie in 1..32");
      end
      if (STAGES < 1 || STAGES > 64) begin : g_bad_stages
         $error("pcc_chain: STAGES must lie in 1..64");
      end
   endgenerate

   logic [STAGES:0] trk;

   assign trk[0] = en_trk;

   generate
      for (genvar k = 0; k < STAGES; k++) begin : g_stage
         pcc_stage #(
            .W        (STAGE_W),
            .SYNC_RST (SYNC_RST)
         ) u_stage (
            .clk    (clk),
            .rst_n  (rst_n),
            .load_n (load_n),
            .din    (din[k*STAGE_W +: STAGE_W]),
            .en_par (en_par),
            .en_trk (trk[k]),
            .q      (count[k*STAGE_W +: STAGE_W]),
            .tc     (trk[k+1])
         );
      end
   endgenerate

   assign carry_out = trk[STAGES];

   logic [TOTAL_W-1:0] unused_w;
   assign unused_w = '0;

endmodule

// File: rtl/pcc_chain_chk.sv
module pcc_chain_chk #(
   parameter int TOTAL_W = 12
) (
   input logic               clk,
   input logic               rst_n,
   input logic               load_n,
   input logic [TOTAL_W-1:0] din,
   input logic               en_par,
   input logic               en_trk,
   input logic [TOTAL_W-1:0] count,
   input logic               carry_out
);

   // R2
   load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load_n |=> (count == $past(din)));

   // R1 R7
   step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load_n && en_par && en_trk) |=> (count == TOTAL_W'($past(count) + 1'b1)));

   // R3 R8
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load_n && !(en_par && en_trk)) |=> $stable(count));

   // R6
   carry_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      carry_out |-> (en_trk && (&count)));

   // R6
   carry_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_trk && (&count)) |-> carry_out);

endmodule

bind pcc_chain pcc_chain_chk #(.TOTAL_W(TOTAL_W)) u_pcc_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .load_n    (load_n),
   .din       (din),
   .en_par    (en_par),
   .en_trk    (en_trk),
   .count     (count),
   .carry_out (carry_out)
);

// File: tb/test_pcc_chain.sv
`timescale 1ns/1ps
module test_pcc_chain;

   localparam int TW = 12;
   localparam int NV = 13;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          load_n = 1'b1;
   logic [TW-1:0] din = '0;
   logic          en_par = 1'b0;
   logic          en_trk = 1'b0;
   logic [TW-1:0] cnt_a, cnt_s;
   logic          cy_a, cy_s;

   int n_tests = 0;
   int n_fail  = 0;

   always #5 clk = ~clk;

   pcc_chain #(.STAGE_W(4), .STAGES(3), .SYNC_RST(1'b0)) i_pcc_chain (
      .clk(clk), .rst_n(rst_n), .load_n(load_n), .din(din),
      .en_par(en_par), .en_trk(en_trk), .count(cnt_a), .carry_out(cy_a)
   );

   pcc_chain #(.STAGE_W(4), .STAGES(3), .SYNC_RST(1'b1)) i_pcc_chain_sync (
      .clk(clk), .rst_n(rst_n), .load_n(load_n), .din(din),
      .en_par(en_par), .en_trk(en_trk), .count(cnt_s), .carry_out(cy_s)
   );

   // {rst_n, load_n, en_par, en_trk, din, expected count, expected carry}
   localparam logic [28:0] VEC [NV] = '{
      {4'b1000, 12'hABC, 12'hABC, 1'b0},  // R2 load with enables low
      {4'b1111, 12'h000, 12'hABD, 1'b0},  // R3 count
      {4'b1011, 12'h0FE, 12'h0FE, 1'b0},  // R2 load beats enables
      {4'b1111, 12'h000, 12'h0FF, 1'b0},  // R6 low stages full, no carry
      {4'b1111, 12'h000, 12'h100, 1'b0},  // R7 carry ripple
      {4'b1011, 12'hFFE, 12'hFFE, 1'b0},  // R2
      {4'b1111, 12'h000, 12'hFFF, 1'b1},  // R6 carry high
      {4'b1101, 12'h000, 12'hFFF, 1'b1},  // R3 hold en_par low, R6
      {4'b1110, 12'h000, 12'hFFF, 1'b0},  // R3 hold en_trk low, R6
      {4'b1111, 12'h000, 12'h000, 1'b0},  // R1 wrap
      {4'b1111, 12'h000, 12'h001, 1'b0},  // R1
      {4'b0011, 12'h555, 12'h000, 1'b0},  // R4 R5 reset beats load
      {4'b1111, 12'h000, 12'h001, 1'b0}   // R3
   };

   task automatic check(input string req, input logic [TW-1:0] act,
                        input logic [TW-1:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic drive(input logic r, input logic l, input logic p,
                        input logic t, input logic [TW-1:0] d);
      rst_n = r; load_n = l; en_par = p; en_trk = t; din = d;
   endtask

   task automatic edge_step();
      @(posedge clk);
      #3;
   endtask

   initial begin : watchdog
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : main
      logic [TW-1:0] mdl;
      repeat (2) @(posedge clk);
      #3;
      check("R4 reset state async", cnt_a, '0);
      check("R5 reset state sync", cnt_s, '0);
      check("R6 reset carry", {11'd0, cy_a}, '0);
      rst_n = 1'b1;
      edge_step();

      for (int i = 0; i < NV; i++) begin
         drive(VEC[i][28], VEC[i][27], VEC[i][26], VEC[i][25], VEC[i][24:13]);
         edge_step();
         check($sformatf("R1-vector %0d async", i), cnt_a, VEC[i][12:1]);
         check($sformatf("R2-vector %0d sync", i), cnt_s, VEC[i][12:1]);
         check($sformatf("R6 vector %0d carry", i), {11'd0, cy_a}, {11'd0, VEC[i][0]});
      end

      // R4 R5: clear between edges
      drive(1'b1, 1'b0, 1'b0, 1'b0, 12'h123);
      edge_step();
      drive(1'b0, 1'b1, 1'b0, 1'b0, 12'h000);
      #1;
      check("R4 async clear without edge", cnt_a, 12'h000);
      check("R5 sync holds before edge", cnt_s, 12'h123);
      check("R8 sync unchanged between edges", cnt_s, 12'h123);
      edge_step();
      check("R5 sync clear at edge", cnt_s, 12'h000);
      rst_n = 1'b1;

      // R6: carry follows en_trk with no edge
      drive(1'b1, 1'b0, 1'b0, 1'b0, 12'hFFF);
      edge_step();
      drive(1'b1, 1'b1, 1'b0, 1'b0, 12'h000);
      #1;
      check("R6 carry low with en_trk low", {11'd0, cy_a}, 12'h000);
      en_trk = 1'b1;
      #1;
      check("R6 carry rises with en_trk", {11'd0, cy_a}, 12'h001);
      check("R6 carry sync variant", {11'd0, cy_s}, 12'h001);
      check("R3 en_par low holds", cnt_a, 12'hFFF);

      // R1 R3 R7: long run against a model
      drive(1'b1, 1'b0, 1'b0, 1'b0, 12'hF00);
      edge_step();
      mdl = 12'hF00;
      for (int i = 0; i < 300; i++) begin
         logic p;
         p = (i % 7) != 3;
         drive(1'b1, 1'b1, p, 1'b1, 12'h000);
         edge_step();
         if (p) mdl = mdl + 12'd1;
         check("R7 chained count async", cnt_a, mdl);
         check("R1 chained count sync", cnt_s, mdl);
      end

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule